// File: doc/BRIEF.md
# PLL Output Clock Gating Controller

This block decides, once per reference clock cycle, whether the always-on functional clock of each of five PLL instances may run or must be held off. Each instance sees its own three-bit operating-mode code and an automatic-idle enable. It also sees one condition from the logic it feeds. For the first two instances this is the power state of the consuming domain. For the third it is an idle flag from the consuming domain. For the last two it is an activity flag from a dependent output clock.

Every instance has its own rule. A stopped clock results from one of two things: a mode code that the instance treats as a stop or bypass, or an automatic-idle request. That request is the auto enable, with the PLL locked and the consumer quiet. The block registers one clock enable per instance for the downstream gate cells. It also registers a two-bit cause code per instance that tells why the clock is stopped. The reset is asynchronous and active low. Its release is synchronised to the reference clock inside the block.

Top module: `pll_out_gate_ctrl`

## Requirements
- R1: Mode codes are 3'b111 locked, 3'b001 low-power stop, 3'b101 low-power bypass and 3'b110 fast-relock bypass. The codes 3'b000, 3'b010, 3'b011 and 3'b100 stop the clock of every instance.
- R2: Instance 0 (enable bit 0) stops in low-power bypass. While locked, it also stops when auto enable is set and its domain power state is off or retention. In stop and fast-relock bypass it runs.
- R3: Instance 1 (enable bit 1) runs only when locked. When locked, it stops if auto enable is set and its domain power state is off or retention.
- R4: Instance 2 (enable bit 2) stops in either bypass mode. While locked, it also stops when auto enable is set and the domain idle flag is high. In low-power stop it runs.
- R5: Instances 3 and 4 (enable bits 3 and 4) stop in low-power stop. While locked, they also stop when auto enable is set and their dependent-clock activity flag (bits 0 and 1 of the flag input) is low. In both bypass modes they run.
- R6: A domain power state field is 2 bits: 2'b00 off, 2'b01 retention, 2'b11 on. The code 2'b10 counts as on. The field of instance 0 sits at bits [1:0] and the field of instance 1 at bits [3:2].
- R7: While reset is asserted the enables read 5'b00101, so instances 0 and 2 run. The status reads 10'h3CC.
- R8: An input change reaches the enables and status on the first rising clock edge after it. Before that edge the outputs keep their previous values.
- R9: The status holds a 2-bit cause per instance at bits [2i+1:2i]: 2'b00 running, 2'b01 stopped by automatic idle, 2'b10 stopped by mode, 2'b11 stopped since reset. When the mode already stops the clock, the cause reads 2'b10.
- R10: The reset release is synchronised over SYNC_STAGES edges. At the first rising edge after the reset input goes high, the outputs still hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 15 | Mode code per instance, instance i at bits [3i+2:3i] |
| auto_en_i | input | 5 | Automatic-idle enable per instance |
| pwr_state_i | input | 4 | Domain power states of instances 0 and 1 |
| dom_idle_i | input | 1 | Idle flag of the domain fed by instance 2 |
| dep_clk_act_i | input | 2 | Dependent-clock activity of instances 3 and 4 |
| clk_en_o | output | 5 | Registered clock enable per instance |
| status_o | output | 10 | Registered stop cause per instance |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This makes the exact cycle in which outputs leave their reset values checkable. For each instance it sweeps all eight mode codes and both auto-enable values. It crosses them with every domain power code for instances 0 and 1, and with both flag levels for the others. This reaches the invalid codes, the unused power code and the mode-over-idle priority of the cause field. A separate scenario changes one input between edges to pin down the one-cycle latency.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int NUM_PLL  = 5;
  localparam int MODE_W   = 3;
  localparam int PWR_W    = 2;
  localparam int CAUSE_W  = 2;
  localparam int NUM_PWR  = 2;
  localparam int IDLE_IDX = NUM_PWR;
  localparam int NUM_DEP  = NUM_PLL - NUM_PWR - 1;
  localparam int N_CODES  = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_STOP  = 3'b001,
    MODE_LPBYP = 3'b101,
    MODE_FRBYP = 3'b110,
    MODE_LOCK  = 3'b111
  } pll_mode_e;

  typedef enum logic [PWR_W-1:0] {
    PWR_OFF = 2'b00,
    PWR_RET = 2'b01,
    PWR_ON  = 2'b11
  } pwr_state_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RUN  = 2'b00,
    CAUSE_IDLE = 2'b01,
    CAUSE_MODE = 2'b10,
    CAUSE_RST  = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    RULE_LPBYP,
    RULE_ALLBYP,
    RULE_BOTHBYP,
    RULE_STOP
  } rule_e;

  // Set of mode codes that stop the clock for a given rule
  function automatic logic [N_CODES-1:0] gate_mask(rule_e r);
    logic [N_CODES-1:0] m;
    m = '1;
    m[MODE_STOP]  = 1'b0;
    m[MODE_LPBYP] = 1'b0;
    m[MODE_FRBYP] = 1'b0;
    m[MODE_LOCK]  = 1'b0;
    case (r)
      RULE_LPBYP:   m[MODE_LPBYP] = 1'b1;
      RULE_ALLBYP: begin
        m[MODE_STOP]  = 1'b1;
        m[MODE_LPBYP] = 1'b1;
        m[MODE_FRBYP] = 1'b1;
      end
      RULE_BOTHBYP: begin
        m[MODE_LPBYP] = 1'b1;
        m[MODE_FRBYP] = 1'b1;
      end
      default:      m[MODE_STOP] = 1'b1;
    endcase
    return m;
  endfunction

  function automatic rule_e rule_of(int i);
    case (i)
      0:       return RULE_LPBYP;
      1:       return RULE_ALLBYP;
      2:       return RULE_BOTHBYP;
      default: return RULE_STOP;
    endcase
  endfunction

  function automatic bit runs_at_reset(int i);
    return (i == 0) || (i == 2);
  endfunction
endpackage

// File: rtl/pgc_rst_sync.sv
module pgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/pgc_gate_rule.sv
module pgc_gate_rule
  import pgc_pkg::*;
#(
  parameter rule_e KIND = RULE_STOP
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              auto_en_i,
  input  logic              idle_req_i,
  output logic              run_o,
  output cause_e            cause_o
);
  localparam logic [N_CODES-1:0] MASK = gate_mask(KIND);

  logic mode_gated;
  logic auto_gated;

  always_comb begin
    mode_gated = MASK[mode_i];
    auto_gated = auto_en_i && (mode_i == MODE_LOCK) && idle_req_i;
    run_o      = !mode_gated && !auto_gated;
    if (mode_gated)      cause_o = CAUSE_MODE;
    else if (auto_gated) cause_o = CAUSE_IDLE;
    else                 cause_o = CAUSE_RUN;
  end
endmodule

// File: rtl/pgc_state_reg.sv
module pgc_state_reg
  import pgc_pkg::*;
#(
  parameter bit RST_RUN = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_d_i,
  input  cause_e cause_d_i,
  output logic   run_o,
  output cause_e cause_o
);
  localparam cause_e RST_CAUSE = RST_RUN ? CAUSE_RUN : CAUSE_RST;

  logic   run_q;
  cause_e cause_q;
  logic   upd_en;

  always_comb begin
    upd_en = (run_d_i != run_q) || (cause_d_i != cause_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= RST_RUN;
      cause_q <= RST_CAUSE;
    end else if (upd_en) begin
      run_q   <= run_d_i;
      cause_q <= cause_d_i;
    end
  end

  assign run_o   = run_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/pll_out_gate_ctrl.sv
module pll_out_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PLL*MODE_W-1:0]   mode_i,
  input  logic [NUM_PLL-1:0]          auto_en_i,
  input  logic [NUM_PWR*PWR_W-1:0]    pwr_state_i,
  input  logic                        dom_idle_i,
  input  logic [NUM_DEP-1:0]          dep_clk_act_i,
  output logic [NUM_PLL-1:0]          clk_en_o,
  output logic [NUM_PLL*CAUSE_W-1:0]  status_o
);
  logic rst_sync_n;

  pgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar gi = 0; gi < NUM_PLL; gi++) begin : g_pll
    logic   idle_req;
    logic   run_d;
    cause_e cause_d;
    cause_e cause_q;

    if (gi < NUM_PWR) begin : g_pwr
      logic [PWR_W-1:0] st;
      assign st       = pwr_state_i[gi*PWR_W +: PWR_W];
      assign idle_req = (st == PWR_OFF) || (st == PWR_RET);
    end else if (gi == IDLE_IDX) begin : g_idle
      assign idle_req = dom_idle_i;
    end else begin : g_dep
      assign idle_req = !dep_clk_act_i[gi-IDLE_IDX-1];
    end

    pgc_gate_rule #(.KIND(rule_of(gi))) u_rule (
      .mode_i     (mode_i[gi*MODE_W +: MODE_W]),
      .auto_en_i  (auto_en_i[gi]),
      .idle_req_i (idle_req),
      .run_o      (run_d),
      .cause_o    (cause_d)
    );

    pgc_state_reg #(.RST_RUN(runs_at_reset(gi))) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .run_d_i   (run_d),
      .cause_d_i (cause_d),
      .run_o     (clk_en_o[gi]),
      .cause_o   (cause_q)
    );

    assign status_o[gi*CAUSE_W +: CAUSE_W] = cause_q;
  end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
  import pgc_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_s,
  input logic [NUM_PLL*MODE_W-1:0]  mode_i,
  input logic [NUM_PLL-1:0]         auto_en_i,
  input logic [NUM_PLL-1:0]         clk_en_o,
  input logic [NUM_PLL*CAUSE_W-1:0] status_o
);
  // R1: an undefined mode code stops instance 4
  a_r1_undef_code_gated: assert property (@(posedge clk_i) disable iff (!rst_s)
    $past(rst_s) && ($past(mode_i[14:12]) == 3'b000) |-> !clk_en_o[4]);

  // R2: instance 0 stops in low-power bypass
  a_r2_lpbyp_gates_first: assert property (@(posedge clk_i) disable iff (!rst_s)
    $past(rst_s) && ($past(mode_i[2:0]) == 3'b101) |-> !clk_en_o[0]);

  // R3: instance 1 never runs outside lock
  a_r3_second_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_s)
    $past(rst_s) && ($past(mode_i[5:3]) != 3'b111) |-> !clk_en_o[1]);

  // R4: instance 2 keeps running in low-power stop
  a_r4_third_runs_in_stop: assert property (@(posedge clk_i) disable iff (!rst_s)
    $past(rst_s) && ($past(mode_i[8:6]) == 3'b001) |-> clk_en_o[2]);

  // R5: instance 3 runs when locked without auto idle
  a_r5_fourth_lock_runs: assert property (@(posedge clk_i) disable iff (!rst_s)
    $past(rst_s) && ($past(mode_i[11:9]) == 3'b111) && !$past(auto_en_i[3])
    |-> clk_en_o[3]);

  // R9: an enable is high exactly when its cause reads running
  for (genvar gi = 0; gi < NUM_PLL; gi++) begin : g_st
    a_r9_cause_matches_enable: assert property (@(posedge clk_i) disable iff (!rst_s)
      $past(rst_s) |-> (clk_en_o[gi] == (status_o[gi*CAUSE_W +: CAUSE_W] == 2'b00)));
  end
endmodule

bind pll_out_gate_ctrl pgc_checker u_pgc_checker (
  .clk_i     (clk_i),
  .rst_s     (rst_sync_n),
  .mode_i    (mode_i),
  .auto_en_i (auto_en_i),
  .clk_en_o  (clk_en_o),
  .status_o  (status_o)
);

// File: tb/pll_out_gate_ctrl_bench.sv
module pll_out_gate_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] mode;
  logic [4:0]  auto_en;
  logic [3:0]  pwr;
  logic        idle_f;
  logic [1:0]  dep_act;
  logic [4:0]  en;
  logic [9:0]  st;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pll_out_gate_ctrl u_pll_out_gate_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mode_i        (mode),
    .auto_en_i     (auto_en),
    .pwr_state_i   (pwr),
    .dom_idle_i    (idle_f),
    .dep_clk_act_i (dep_act),
    .clk_en_o      (en),
    .status_o      (st)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected {run, cause} from the written rules
  function automatic logic [2:0] model(int inst, logic [2:0] m, logic a, logic [1:0] dom);
    bit valid, mg, idle, ag;
    logic [1:0] cause;
    valid = (m == 3'b001) || (m == 3'b101) || (m == 3'b110) || (m == 3'b111);
    case (inst)
      0:       mg = !valid || (m == 3'b101);
      1:       mg = (m != 3'b111);
      2:       mg = !valid || (m == 3'b101) || (m == 3'b110);
      default: mg = !valid || (m == 3'b001);
    endcase
    if (inst < 2)       idle = (dom == 2'b00) || (dom == 2'b01);
    else if (inst == 2) idle = dom[0];
    else                idle = !dom[0];
    ag = a && (m == 3'b111) && idle;
    cause = mg ? 2'b10 : (ag ? 2'b01 : 2'b00);
    return {!(mg || ag), cause};
  endfunction

  task automatic drive(int inst, logic [2:0] m, logic a, logic [1:0] dom);
    mode[inst*3 +: 3] = m;
    auto_en[inst]     = a;
    if (inst < 2)       pwr[inst*2 +: 2] = dom;
    else if (inst == 2) idle_f = dom[0];
    else                dep_act[inst-3] = dom[0];
  endtask

  task automatic all_running_inputs();
    mode    = {5{3'b111}};
    auto_en = '0;
    pwr     = 4'b1111;
    idle_f  = 1'b0;
    dep_act = 2'b11;
  endtask

  // R7, R10: reset values and synchronised release
  task automatic t_reset();
    rst_n = 1'b0;
    all_running_inputs();
    repeat (3) @(negedge clk);
    check("R7 enables in reset", 16'(en), 16'h05);
    check("R7 status in reset", 16'(st), 16'h3CC);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 enables one edge after release", 16'(en), 16'h05);
    check("R10 status one edge after release", 16'(st), 16'h3CC);
    repeat (2) @(negedge clk);
    check("R10 enables follow inputs after sync", 16'(en), 16'h1F);
    check("R9 all causes running", 16'(st), 16'h000);
  endtask

  // R1-R6, R9: exhaustive sweep of one instance
  task automatic t_sweep(int inst);
    int ndom;
    string tag;
    ndom = (inst < 2) ? 4 : 2;
    case (inst)
      0:       tag = "R2/R1/R6/R9";
      1:       tag = "R3/R1/R6/R9";
      2:       tag = "R4/R1/R9";
      default: tag = "R5/R1/R9";
    endcase
    all_running_inputs();
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int d = 0; d < ndom; d++) begin
          logic [2:0] exp;
          exp = model(inst, 3'(m), 1'(a), 2'(d));
          drive(inst, 3'(m), 1'(a), 2'(d));
          @(negedge clk);
          check($sformatf("%s inst%0d mode%0d auto%0d dom%0d", tag, inst, m, a, d),
                16'({en[inst], st[inst*2 +: 2]}), 16'(exp));
        end
      end
    end
    all_running_inputs();
    @(negedge clk);
  endtask

  // R8: outputs change on the first edge after an input change
  task automatic t_latency();
    all_running_inputs();
    @(negedge clk);
    check("R8 settled before change", 16'(en), 16'h1F);
    mode[5:3] = 3'b001;
    #1;
    check("R8 no change before edge", 16'(en), 16'h1F);
    @(negedge clk);
    check("R8 change after one edge", 16'(en), 16'h1D);
    check("R9 mode cause of instance 1", 16'(st[3:2]), 16'h2);
    auto_en[3] = 1'b1;
    dep_act[0] = 1'b0;
    #1;
    check("R8 auto idle not yet visible", 16'(en[3]), 16'h1);
    @(negedge clk);
    check("R5 auto idle stops instance 3", 16'(en[3]), 16'h0);
    check("R9 idle cause of instance 3", 16'(st[7:6]), 16'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int i = 0; i < 5; i++) t_sweep(i);
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule